// File: doc/BRIEF.md
# Memory Test Pattern Generator

This block exercises an external memory through a memory controller's word-wide command port. A terminal-count divider produces a once-per-second tick. Each tick asks for one test sequence. A sequence first writes a 16-bit pattern to every word of a fixed region, in ascending address order. It then reads the same region back in the same order and checks every returned word against the pattern it expects. A tick that arrives while a sequence is still running is held until the block goes idle.

Each pattern word is built from two bytes. The high byte is the number of ticks seen since reset, frozen for the whole sequence. The low byte is the word address modulo 256. Returned words are matched to requests in issue order. Each one is copied into a 256-entry local buffer at index address modulo 256, so every entry keeps the last word read back for that index. The buffer can be read through a registered read port.

At the end of each read-back the block emits a one-cycle done pulse. A sticky error flag records any mismatch. An indicator output toggles after every clean sequence and stays on once an error has been latched.

Top module: `mem_pattern_tester`

## Requirements
- R1: While rst_n is low, and after it is released until the first tick, mem_wr, mem_rd, pass_done, err_flag and led are all 0.
- R2: A tick occurs every TICK_COUNT clock edges after reset is released. Each tick requests one sequence. A request made while a sequence runs is held, and further ticks in the meantime do not add requests. A held or new request starts a sequence on the edge after the block is idle, and no command is issued outside a sequence.
- R3: The write phase issues exactly REGION_WORDS writes to addresses 0, 1, 2 and so on in order. A command counts as accepted on an edge where mem_wait is low. While mem_wait is high the command, its address and its data are held. mem_wr and mem_rd are never high together.
- R4: Write data is {hi, addr[7:0]}. Bits 15:8 (hi) are the tick count, modulo 256, at the edge where the sequence started, and stay constant for the whole sequence. Bits 7:0 are the word address modulo 256.
- R5: The read phase starts only after the last write has been accepted. It issues exactly REGION_WORDS reads to ascending addresses starting at 0.
- R6: The n-th mem_rvalid beat of a sequence carries the word for address n. It is stored at buffer index n mod BUF_WORDS. buf_rdata shows the entry at buf_raddr one clock after it is presented.
- R7: pass_done is a one-cycle pulse that rises on the edge after the last read-data beat of a sequence has been captured.
- R8: err_flag rises when any returned word differs from {hi, addr[7:0]} of its sequence, and it then stays high until reset.
- R9: While err_flag is low, led toggles at each pass_done (led = number of completed sequences mod 2). While err_flag is high, led is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (100 MHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W | Word address of the current command |
| mem_wdata | output | 16 | Pattern word for a write command |
| mem_wr | output | 1 | Write request |
| mem_rd | output | 1 | Read request |
| mem_wait | input | 1 | Controller stall; a command is accepted on an edge where this is low |
| mem_rdata | input | 16 | Returned read word |
| mem_rvalid | input | 1 | mem_rdata valid, one beat per read in issue order |
| buf_raddr | input | BUF_AW | Local buffer read index |
| buf_rdata | output | 16 | Local buffer word, one clock after buf_raddr |
| pass_done | output | 1 | One-cycle pulse at the end of each read-back |
| err_flag | output | 1 | Sticky mismatch flag |
| led | output | 1 | Indicator: toggles per clean sequence, steady on after an error |

## Verification
The bench builds the block with TICK_COUNT = 3000 and keeps the default 1024-word region and 256-entry buffer. Every write and read is then visible in simulation, and the buffer index wraps four times per read-back. The controller model stalls on about 40 % of cycles and returns data after 1 to 6 cycles, so each sequence lasts longer than one tick period. A tick therefore always arrives while the block is busy, and the held-request path runs on every pass after the first. A word corrupted in the third pass drives the sticky error flag and the change of the indicator from toggling to steady.

// File: rtl/mem_pattern_tester.sv
module mem_pattern_tester #(
  parameter int TICK_COUNT   = 100_000_000,
  parameter int REGION_WORDS = 1024,
  parameter int BUF_WORDS    = 256,
  localparam int ADDR_W = $clog2(REGION_WORDS),
  localparam int BUF_AW = $clog2(BUF_WORDS),
  localparam int TW     = $clog2(TICK_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  output logic              mem_wr,
  output logic              mem_rd,
  input  logic              mem_wait,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_rvalid,
  input  logic [BUF_AW-1:0] buf_raddr,
  output logic [15:0]       buf_rdata,
  output logic              pass_done,
  output logic              err_flag,
  output logic              led
);

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_READ, S_DRAIN} state_t;

  state_t            state;
  logic [TW-1:0]     div_cnt;
  logic [7:0]        sec_cnt;
  logic [7:0]        hi;
  logic              pending;
  logic [ADDR_W-1:0] cmd_addr;
  logic [ADDR_W-1:0] ret_cnt;
  logic [ADDR_W:0]   outst;
  logic              led_t;
  logic [15:0]       buf_mem [BUF_WORDS];

  wire tick     = div_cnt == TW'(TICK_COUNT - 1);
  wire start    = (state == S_IDLE) && pending;
  wire accept   = (state == S_WRITE || state == S_READ) && !mem_wait;
  wire rd_acc   = (state == S_READ) && !mem_wait;
  wire cmd_last = cmd_addr == ADDR_W'(REGION_WORDS - 1);
  wire ret_last = ret_cnt == ADDR_W'(REGION_WORDS - 1);
  wire finish   = (state == S_DRAIN) && mem_rvalid && ret_last;
  wire [15:0] expect_word = {hi, 8'(ret_cnt)};

  assign mem_addr  = cmd_addr;
  assign mem_wdata = {hi, 8'(cmd_addr)};
  assign mem_wr    = state == S_WRITE;
  assign mem_rd    = state == S_READ;
  assign led       = err_flag | led_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sec_cnt <= '0;
      pending <= 1'b0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) sec_cnt <= sec_cnt + 1'b1;
      pending <= tick | (pending & ~start);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      hi       <= '0;
      cmd_addr <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state    <= S_WRITE;
          hi       <= sec_cnt;
          cmd_addr <= '0;
        end
        S_WRITE: if (accept) begin
          if (cmd_last) begin
            state    <= S_READ;
            cmd_addr <= '0;
          end else cmd_addr <= cmd_addr + 1'b1;
        end
        S_READ: if (accept) begin
          if (cmd_last) state <= S_DRAIN;
          else cmd_addr <= cmd_addr + 1'b1;
        end
        default: if (finish) state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_cnt   <= '0;
      outst     <= '0;
      err_flag  <= 1'b0;
      pass_done <= 1'b0;
      led_t     <= 1'b0;
    end else begin
      if (start) ret_cnt <= '0;
      else if (mem_rvalid) ret_cnt <= ret_cnt + 1'b1;
      outst     <= outst + (ADDR_W+1)'(rd_acc) - (ADDR_W+1)'(mem_rvalid);
      err_flag  <= err_flag | (mem_rvalid && mem_rdata != expect_word);
      pass_done <= finish;
      if (finish) led_t <= ~led_t;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_rvalid) buf_mem[ret_cnt[BUF_AW-1:0]] <= mem_rdata;
    buf_rdata <= buf_mem[buf_raddr];
  end

  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || mem_rd) && mem_wait |=>
      mem_wr == $past(mem_wr) && mem_rd == $past(mem_rd) && $stable(mem_addr) && $stable(mem_wdata));

  assert_cmd_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));

  assert_no_orphan_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> outst != 0);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> !pass_done);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_led_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> led);

  assert_hi_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || mem_rd) && $past(mem_wr || mem_rd) |-> $stable(mem_wdata[15:8]));

endmodule

// File: tb/mem_pattern_tester_tb.sv
module mem_pattern_tester_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 3000;
  localparam int REGION     = 1024;
  localparam int BUFW       = 256;
  localparam int AW         = 10;
  localparam int BAW        = 8;
  localparam int N_PASSES   = 5;
  localparam int ERR_PASS   = 3;
  localparam int ERR_ADDR   = 5;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0]  mem_addr;
  logic [15:0]    mem_wdata, mem_rdata = 0, buf_rdata;
  logic           mem_wr, mem_rd, mem_wait = 0, mem_rvalid = 0;
  logic [BAW-1:0] buf_raddr = 0;
  logic           pass_done, err_flag, led;

  mem_pattern_tester #(.TICK_COUNT(TICK), .REGION_WORDS(REGION), .BUF_WORDS(BUFW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wait(mem_wait), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .pass_done(pass_done), .err_flag(err_flag), .led(led));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, misses = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pattern(input int h, input int a);
    return {8'(h), 8'(a)};
  endfunction

  logic edge_live = 0;
  always @(posedge clk) edge_live = rst_n;

  int ncyc = 0, ecount = 0, m_sec = 0, m_hi = 0, done_hi = 0;
  bit m_pend = 0, m_idle = 1, err_exp = 0;
  int passes_started = 0, passes_done = 0;
  int wr_idx = 0, rd_idx = 0, ret = 0;
  logic [15:0] mem_model [REGION];
  int q_addr [2048];
  int q_due  [2048];
  int qh = 0, qt = 0, last_due = 0;

  always @(negedge clk) begin
    ncyc++;
    if (rst_n && edge_live) begin
      bit tick_k, start;
      ecount++;
      tick_k = (ecount % TICK) == 0;
      start  = m_idle && m_pend;
      if (start) begin
        m_hi = m_sec % 256;
        passes_started++;
        wr_idx = 0; rd_idx = 0; ret = 0;
      end
      m_idle = (m_idle && !start) || pass_done;
      m_pend = tick_k || (m_pend && !start);
      if (tick_k) m_sec++;

      if (pass_done) begin
        passes_done++;
        done_hi = m_hi;
        chk(rd_idx == REGION, "R7", "reads accepted at pass_done", rd_idx, REGION);
        chk(ret == REGION, "R7", "beats returned at pass_done", ret, REGION);
        chk(err_flag == err_exp, "R8", "err_flag after pass", int'(err_flag), int'(err_exp));
        chk(led == (err_exp ? 1'b1 : 1'(passes_done % 2)), "R9", "led after pass",
            int'(led), err_exp ? 1 : passes_done % 2);
      end
      if (m_idle && (mem_wr || mem_rd))
        chk(0, "R2", "command while no sequence requested", int'({mem_wr, mem_rd}), 0);

      mem_wait = ($urandom % 100) < 40;

      if (mem_wr && mem_rd) chk(0, "R3", "wr and rd together", 3, 0);
      if (mem_wr && !mem_wait) begin
        chk(wr_idx < REGION, "R3", "write count", wr_idx, REGION - 1);
        chk(mem_addr == AW'(wr_idx), "R3", "write address", int'(mem_addr), wr_idx);
        chk(mem_wdata == pattern(m_hi, wr_idx), "R4", "write data", int'(mem_wdata),
            int'(pattern(m_hi, wr_idx)));
        mem_model[wr_idx % REGION] = mem_wdata;
        wr_idx++;
      end
      if (mem_rd) begin
        if (rd_idx == 0 && wr_idx != REGION)
          chk(0, "R5", "read before write phase complete", wr_idx, REGION);
        if (!mem_wait) begin
          int lat, due;
          chk(mem_addr == AW'(rd_idx), "R5", "read address", int'(mem_addr), rd_idx);
          lat = 1 + int'($urandom % 6);
          due = ncyc + lat;
          if (due <= last_due) due = last_due + 1;
          last_due = due;
          q_addr[qt % 2048] = rd_idx;
          q_due[qt % 2048]  = due;
          qt++;
          rd_idx++;
        end
      end

      mem_rvalid = 0;
      if (qh != qt && q_due[qh % 2048] <= ncyc) begin
        int a;
        a = q_addr[qh % 2048];
        qh++;
        mem_rvalid = 1;
        mem_rdata  = mem_model[a % REGION];
        if (passes_started == ERR_PASS && a == ERR_ADDR) begin
          mem_rdata = mem_rdata ^ 16'h0001;
          err_exp   = 1;
        end
        ret++;
      end
    end else begin
      mem_wait   = 0;
      mem_rvalid = 0;
    end
  end

  task automatic check_buf(input int idx, input int h);
    buf_raddr = BAW'(idx);
    @(negedge clk);
    chk(buf_rdata == pattern(h, idx), "R6", "buffer entry", int'(buf_rdata), int'(pattern(h, idx)));
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    chk({mem_wr, mem_rd, pass_done, err_flag, led} == 5'b0, "R1", "outputs in reset",
        int'({mem_wr, mem_rd, pass_done, err_flag, led}), 0);
    rst_n = 1;
    repeat (TICK - 10) @(negedge clk);
    chk({mem_wr, mem_rd, pass_done, err_flag, led} == 5'b0, "R1", "outputs before first tick",
        int'({mem_wr, mem_rd, pass_done, err_flag, led}), 0);
    chk(passes_started == 0, "R2", "no sequence before tick", passes_started, 0);
    for (int p = 1; p <= N_PASSES; p++) begin
      wait (passes_done >= p);
      @(negedge clk);
      check_buf(0, done_hi);
      check_buf(BUFW - 1, done_hi);
      check_buf(ERR_ADDR, done_hi);
      for (int k = 0; k < 3; k++) check_buf(int'($urandom % BUFW), done_hi);
      if (p == 1) chk(done_hi == 1, "R4", "first pass high byte", done_hi, 1);
    end
    chk(err_flag == 1, "R8", "err_flag held at end", int'(err_flag), 1);
    chk(led == 1, "R9", "led steady after error", int'(led), 1);
    chk(passes_started >= N_PASSES, "R2", "sequences started", passes_started, N_PASSES);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    misses++;
    $display("FAIL watchdog: actual=%0d expected=%0d passes done", passes_done, N_PASSES);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule